// File: doc/BRIEF.md
# Registration-Based Fair Bus Arbiter

This block is the central controller that shares an expansion bus among several plug-in cards and the host CPU. It hands out mastership one full bus cycle at a time. Each card has a private active-low request line and a private active-low grant line. A card does not hold its request line while it waits. It sends a one-clock pulse to join the schedule and a second pulse to leave it. The arbiter keeps one registration bit per card. It rotates the bus among registered cards and the CPU with a round-robin pointer, so no master can hold the bus at the expense of the others.

A granted master starts its full cycle by driving the shared active-low cycle strobe. It may run any number of transfers before it releases the strobe. The arbiter withdraws the grant once the strobe is seen, unless the bus lock input is raised, in which case the same master receives consecutive full cycles. A cycle whose strobe stays low too long raises a bus error, and the master that owned that cycle loses its registration. A granted card that pulses its request before starting a cycle gives the bus back at once. The arbiter also drives the bus-ownership and grant-acknowledge strobes that tell the rest of the system a card holds the bus.

Top module: `fair_bus_arbiter`

## Requirements
- R1: A card's registration bit toggles on each rising edge at which its request line is sampled low after being sampled high on the previous edge. A pulse from an unregistered card registers it, and a pulse from a registered card unregisters it.
- R2: The CPU competes whenever `cpu_req_i` is high, without registering. A card that is not registered is never granted. After reset, while nothing is eligible, no grant is active.
- R3: Slots are numbered 0 for the CPU and i+1 for card i. When the arbiter is idle and some slot is eligible, it grants on the next edge the first eligible slot after the previous winner, searching upward and wrapping. The previous winner is slot 0 after reset.
- R4: A grant stays active from selection until the edge at which the cycle strobe is first sampled low. The grant is then released unless lock is high. Each grant covers one full cycle, and the bus goes idle for one clock after the strobe is released.
- R5: While `lock_i` is high, the grant stays active during the cycle. If the master is still eligible when the strobe is released, the same master is granted again on that edge, with no idle clock and no pointer movement.
- R6: If the strobe stays low for TIMEOUT_CYCLES edges after the edge that started the cycle, `berr_o` goes high and stays high until the strobe is released. The owning card is unregistered on that same edge, and the bus returns to idle one edge after release.
- R7: If a granted card pulses its request before asserting the strobe, or the CPU drops `cpu_req_i` while granted, the grant is withdrawn on that edge and the next eligible master is chosen on the following edge.
- R8: `bus_own_no` is low while a card (not the CPU) is granted, running or draining a cycle. `grant_ack_no` is low only while a card runs or drains a cycle. Both stay high for the CPU and when the bus is idle.
- R9: At most one of the card grant lines and `cpu_grant_o` is active at any time, and none is active while the bus is idle.
- R10: During reset all grant lines are high, `cpu_grant_o` and `berr_o` are low, `bus_own_no` and `grant_ack_no` are high, and every card is unregistered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock; all sampling on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | CPU wants bus cycles (level) |
| req_ni | input | N_CARDS | Per-card active-low registration pulse lines |
| cyc_strobe_ni | input | 1 | Active-low full-cycle strobe driven by the current master |
| lock_i | input | 1 | Bus lock; keeps granting the current master |
| grant_no | output | N_CARDS | Per-card active-low grant lines |
| cpu_grant_o | output | 1 | Grant to the CPU slot, active high |
| bus_own_no | output | 1 | Active low while a card owns the bus |
| grant_ack_no | output | 1 | Active low while a card runs a cycle |
| berr_o | output | 1 | Bus error after a cycle timeout |

## Verification
The hardest cases to reach are those in which the registration set changes while a grant is outstanding. Any pulse that lands while the arbiter is idle or granting races the selection. The bench therefore applies every registration change while it holds a cycle strobe low, so each next winner follows from a known set. It then sweeps all sixteen card subsets, paired with CPU participation, through several rotations each. Lock re-grant, unregistering while granted and the timeout are reached by directed sequences on top of a known pointer position. After the timeout, further rotations confirm that the timed-out card never wins again.

// File: rtl/fba_pkg.sv
package fba_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GRANT,
    ST_CYCLE,
    ST_DRAIN
  } fba_state_e;
endpackage

// File: rtl/fba_regbank.sv
module fba_regbank #(
  parameter int N_CARDS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CARDS-1:0] req_ni,
  input  logic [N_CARDS-1:0] clr_i,
  output logic [N_CARDS-1:0] reg_o,
  output logic [N_CARDS-1:0] tog_o
);
  logic [N_CARDS-1:0] prev_q, reg_q;

  // a request counts once per falling sample, even if held
  assign tog_o = prev_q & ~req_ni;
  assign reg_o = reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '1;
      reg_q  <= '0;
    end else begin
      prev_q <= req_ni;
      reg_q  <= (reg_q ^ tog_o) & ~clr_i;
    end
  end

  for (genvar gi = 0; gi < N_CARDS; gi++) begin : g_chk
    // R1
    toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(req_ni[gi]) && !clr_i[gi]) |=> (reg_o[gi] != $past(reg_o[gi])));
    // R6
    clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[gi] |=> !reg_o[gi]);
  end
endmodule

// File: rtl/fba_rr_pick.sv
module fba_rr_pick #(
  parameter int SLOTS  = 5,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0]  elig_i,
  input  logic [SLOT_W-1:0] ptr_i,
  output logic              valid_o,
  output logic [SLOT_W-1:0] win_o
);
  int cand;

  // walk backwards so the slot nearest after ptr_i is written last
  always_comb begin
    valid_o = 1'b0;
    win_o   = '0;
    cand    = 0;
    for (int k = SLOTS; k >= 1; k--) begin
      cand = int'(ptr_i) + k;
      if (cand >= SLOTS) cand = cand - SLOTS;
      if (elig_i[cand]) begin
        valid_o = 1'b1;
        win_o   = SLOT_W'(cand);
      end
    end
  end
endmodule

// File: rtl/fba_timeout.sv
module fba_timeout #(
  parameter int LIMIT = 32,
  parameter int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic fire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign fire_o = run_i && (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (!fire_o) cnt_q <= cnt_q + 1'b1;
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(LIMIT));

  if (LIMIT > 1) begin : g_run_chk
    // R6
    fire_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o |-> $past(run_i));
  end
endmodule

// File: rtl/fair_bus_arbiter.sv
module fair_bus_arbiter
  import fba_pkg::*;
#(
  parameter int N_CARDS        = 4,
  parameter int TIMEOUT_CYCLES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpu_req_i,
  input  logic [N_CARDS-1:0] req_ni,
  input  logic               cyc_strobe_ni,
  input  logic               lock_i,
  output logic [N_CARDS-1:0] grant_no,
  output logic               cpu_grant_o,
  output logic               bus_own_no,
  output logic               grant_ack_no,
  output logic               berr_o
);
  localparam int SLOTS  = N_CARDS + 1;
  localparam int SLOT_W = $clog2(SLOTS);

  fba_state_e st_q, st_d;
  logic [SLOT_W-1:0] owner_q, owner_d, ptr_q, ptr_d, pick_win;
  logic [N_CARDS-1:0] reg_w, tog_w, clr_w, own_mask;
  logic [SLOTS-1:0] elig_w;
  logic pick_valid, tmo_fire, tmo_run, owner_leave, owner_elig, card_owner, granting;

  assign elig_w     = {reg_w, cpu_req_i};
  assign card_owner = (owner_q != '0);
  assign owner_elig = elig_w[owner_q];
  assign tmo_run    = (st_q == ST_CYCLE) && !cyc_strobe_ni;

  fba_regbank #(.N_CARDS(N_CARDS)) i_regbank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_ni(req_ni),
    .clr_i (clr_w),
    .reg_o (reg_w),
    .tog_o (tog_w)
  );

  fba_rr_pick #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) i_pick (
    .elig_i (elig_w),
    .ptr_i  (ptr_q),
    .valid_o(pick_valid),
    .win_o  (pick_win)
  );

  fba_timeout #(.LIMIT(TIMEOUT_CYCLES)) i_timeout (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (tmo_run),
    .fire_o(tmo_fire)
  );

  always_comb begin
    for (int i = 0; i < N_CARDS; i++) own_mask[i] = (owner_q == SLOT_W'(i + 1));
    clr_w       = own_mask & {N_CARDS{(st_q == ST_CYCLE) && tmo_fire}};
    owner_leave = (|(own_mask & tog_w & reg_w)) || (!card_owner && !cpu_req_i);
  end

  always_comb begin
    st_d    = st_q;
    owner_d = owner_q;
    ptr_d   = ptr_q;
    unique case (st_q)
      ST_IDLE: if (pick_valid) begin
        st_d    = ST_GRANT;
        owner_d = pick_win;
        ptr_d   = pick_win;
      end
      ST_GRANT: begin
        if (owner_leave)         st_d = ST_IDLE;
        else if (!cyc_strobe_ni) st_d = ST_CYCLE;
      end
      ST_CYCLE: begin
        if (tmo_fire)           st_d = ST_DRAIN;
        else if (cyc_strobe_ni) st_d = (lock_i && owner_elig) ? ST_GRANT : ST_IDLE;
      end
      ST_DRAIN: if (cyc_strobe_ni) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      owner_q <= '0;
      ptr_q   <= '0;
    end else begin
      st_q    <= st_d;
      owner_q <= owner_d;
      ptr_q   <= ptr_d;
    end
  end

  assign granting = (st_q == ST_GRANT) || ((st_q == ST_CYCLE) && lock_i);

  always_comb begin
    for (int i = 0; i < N_CARDS; i++) grant_no[i] = !(granting && own_mask[i]);
  end
  assign cpu_grant_o  = granting && !card_owner;
  assign bus_own_no   = !((st_q != ST_IDLE) && card_owner);
  assign grant_ack_no = !(((st_q == ST_CYCLE) || (st_q == ST_DRAIN)) && card_owner);
  assign berr_o       = (st_q == ST_DRAIN);

  // R9
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~grant_no, cpu_grant_o}));
  // R3
  idle_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && |elig_w) |=> (st_q == ST_GRANT));
  // R4
  grant_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_GRANT && !cyc_strobe_ni && !owner_leave)
      |=> (lock_i || (grant_no == '1 && !cpu_grant_o)));
  // R5
  lock_regrant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CYCLE && cyc_strobe_ni && lock_i && owner_elig)
      |=> (st_q == ST_GRANT && owner_q == $past(owner_q)));
  // R7
  leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_GRANT && owner_leave) |=> (grant_no == '1 && !cpu_grant_o));
  // R6
  berr_unreg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(berr_o) && card_owner) |-> !elig_w[owner_q]);
  // R8
  own_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_ack_no |-> !bus_own_no);
endmodule

// File: tb/test_fair_bus_arbiter.sv
module test_fair_bus_arbiter;
  localparam int N = 4;
  localparam int T = 12;
  localparam int S = N + 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cpu_req_i = 1'b0;
  logic [N-1:0] req_ni = '1;
  logic cyc_strobe_ni = 1'b1;
  logic lock_i = 1'b0;
  logic [N-1:0] grant_no;
  logic cpu_grant_o, bus_own_no, grant_ack_no, berr_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [N-1:0] m_reg = '0;
  bit m_cpu = 1'b0;
  int m_ptr = 0;

  always #5 clk_i = ~clk_i;

  fair_bus_arbiter #(.N_CARDS(N), .TIMEOUT_CYCLES(T)) i_fair_bus_arbiter (
    .clk_i(clk_i), .rst_ni(rst_ni), .cpu_req_i(cpu_req_i), .req_ni(req_ni),
    .cyc_strobe_ni(cyc_strobe_ni), .lock_i(lock_i), .grant_no(grant_no),
    .cpu_grant_o(cpu_grant_o), .bus_own_no(bus_own_no),
    .grant_ack_no(grant_ack_no), .berr_o(berr_o)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int read_slot();
    int cnt = 0;
    int s = -1;
    if (cpu_grant_o) begin cnt++; s = 0; end
    for (int i = 0; i < N; i++) if (!grant_no[i]) begin cnt++; s = i + 1; end
    if (cnt > 1) s = -2;
    return s;
  endfunction

  function automatic int model_pick();
    for (int k = 1; k <= S; k++) begin
      int s = (m_ptr + k) % S;
      if (s == 0 ? m_cpu : m_reg[s-1]) return s;
    end
    return -1;
  endfunction

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic pulse(input logic [N-1:0] mask);
    if (mask != '0) begin
      req_ni = ~mask;
      tick();
      req_ni = '1;
      m_reg = m_reg ^ mask;
    end
  endtask

  // entry and exit: at a falling edge with the arbiter idle
  task automatic do_cycle(input bit apply, input logic [N-1:0] target,
                          input bit cpu_new, input int hold);
    int exp, s;
    exp = model_pick();
    if (exp >= 0) m_ptr = exp;
    tick();
    s = read_slot();
    chk(s == exp, "R3", s, exp);
    chk(bus_own_no == (exp == 0), "R8", int'(bus_own_no), int'(exp == 0));
    chk(grant_ack_no == 1'b1, "R8", int'(grant_ack_no), 1);
    cyc_strobe_ni = 1'b0;
    tick();
    s = read_slot();
    chk(s == -1, "R4", s, -1);
    chk(grant_ack_no == (exp == 0), "R8", int'(grant_ack_no), int'(exp == 0));
    if (apply) begin
      pulse(m_reg ^ target);
      m_cpu = cpu_new;
      cpu_req_i = cpu_new;
    end
    repeat (hold) tick();
    cyc_strobe_ni = 1'b1;
    tick();
    s = read_slot();
    chk(s == -1, "R9", s, -1);
    chk(bus_own_no == 1'b1, "R8", int'(bus_own_no), 1);
  endtask

  // R9: grant exclusivity every cycle
  always @(negedge clk_i) begin
    if (rst_ni) chk(read_slot() != -2, "R9", read_slot(), -1);
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int exp, s;
    repeat (3) @(negedge clk_i);
    // R10
    chk(grant_no == '1, "R10", int'(grant_no), 15);
    chk(!cpu_grant_o && !berr_o, "R10", int'({cpu_grant_o, berr_o}), 0);
    chk(bus_own_no && grant_ack_no, "R10", int'({bus_own_no, grant_ack_no}), 3);
    rst_ni = 1'b1;
    repeat (3) begin
      tick();
      chk(read_slot() == -1, "R2", read_slot(), -1);
    end

    cpu_req_i = 1'b1;
    m_cpu = 1'b1;
    // R1 R2 R3: all card subsets with and without the CPU
    for (int m = 0; m < 16; m++) begin
      for (int r = 0; r < 5; r++)
        do_cycle(r == 0, 4'(m), (m == 0) || (m % 3 == 0), m % 3);
    end

    // R5: lock keeps the same master
    do_cycle(1'b1, 4'b1011, 1'b0, 1);
    exp = model_pick();
    m_ptr = exp;
    tick();
    chk(read_slot() == exp, "R3", read_slot(), exp);
    lock_i = 1'b1;
    cyc_strobe_ni = 1'b0;
    tick();
    chk(read_slot() == exp, "R5", read_slot(), exp);
    cyc_strobe_ni = 1'b1;
    tick();
    chk(read_slot() == exp, "R5", read_slot(), exp);
    lock_i = 1'b0;
    cyc_strobe_ni = 1'b0;
    tick();
    chk(read_slot() == -1, "R4", read_slot(), -1);
    cyc_strobe_ni = 1'b1;
    tick();
    chk(read_slot() == -1, "R9", read_slot(), -1);
    do_cycle(1'b0, '0, 1'b0, 0);

    // R7: granted card leaves before its strobe
    exp = model_pick();
    m_ptr = exp;
    tick();
    chk(read_slot() == exp, "R3", read_slot(), exp);
    req_ni[exp-1] = 1'b0;
    tick();
    chk(read_slot() == -1, "R7", read_slot(), -1);
    req_ni = '1;
    m_reg[exp-1] = 1'b0;
    do_cycle(1'b0, '0, 1'b0, 0);
    do_cycle(1'b0, '0, 1'b0, 0);

    // R6: timeout unregisters the owner
    do_cycle(1'b1, 4'b0101, 1'b0, 0);
    exp = model_pick();
    m_ptr = exp;
    tick();
    chk(read_slot() == exp, "R3", read_slot(), exp);
    cyc_strobe_ni = 1'b0;
    tick();
    repeat (T - 1) tick();
    chk(berr_o == 1'b0, "R6", int'(berr_o), 0);
    tick();
    chk(berr_o == 1'b1, "R6", int'(berr_o), 1);
    chk(!bus_own_no && !grant_ack_no, "R8", int'({bus_own_no, grant_ack_no}), 0);
    repeat (2) tick();
    chk(berr_o == 1'b1, "R6", int'(berr_o), 1);
    cyc_strobe_ni = 1'b1;
    tick();
    chk(berr_o == 1'b0, "R6", int'(berr_o), 0);
    s = read_slot();
    chk(s == -1, "R6", s, -1);
    m_reg[exp-1] = 1'b0;
    cpu_req_i = 1'b1;
    m_cpu = 1'b1;
    repeat (4) do_cycle(1'b0, '0, 1'b0, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule